// File: doc/BRIEF.md
# Core-local leveled interrupt controller

This block sits beside a single processor hart. It gathers a set of interrupt lines, records which of them are pending, masks them with per-line enables, and presents one winning request to the core. Software programs it through a byte-wide register bus. There is a global split setting, a threshold byte, a read-only information word, and a four-byte group for each line. The four bytes of a group hold the pending flag, the enable flag, an attribute byte (trigger mode and vectored flag) and an 8-bit control byte.

The control byte is divided at run time by the split setting (the number of level bits). Its upper part is the interrupt level and the bits below form the priority. Both fields are left-aligned toward bit 7. Control bits that are not implemented always read as ones. Arbitration takes the highest level first, then the highest priority, then the highest line number. The request goes to the core only when the winning level is strictly above the threshold. The winner's number, level and vectored flag travel with the request. The core can acknowledge a line to clear an edge-latched pending flag.

Top module: `lvl_intc`

## Requirements
- R1: After reset the split byte (offset 0x000), the threshold (offset 0x00B) and every line's pending, enable and attribute bytes read 0x00. Every control byte reads 0x0F (with 4 implemented control bits), and the request is low.
- R2: Offsets 0x004..0x007 read, low byte first, a 32-bit word with the line count in bits 12:0, the version in bits 20:13 and the implemented control-bit count in bits 24:21. Writes do not change it.
- R3: The low (8 − implemented bits) bits of a control byte (offset 0x1000 + 4·n + 3) read as ones whatever is written. The upper bits read back as written.
- R4: A line whose trigger field (attribute bits 2:1) is 0 has a pending flag that follows its input after a two-flop synchronizer. Software writes to that pending flag have no effect.
- R5: A line with trigger field 1 latches pending on a rising input edge and holds it after the input falls. The flag is cleared by writing 0 to the pending byte (offset 0x1000 + 4·n) or by an acknowledge naming the line.
- R6: A line with trigger field 2 latches pending on a falling input edge and not on a rising one. It is cleared by writing 0.
- R7: A line that is pending but not enabled (enable byte bit 0, offset 0x1000 + 4·n + 1) never wins arbitration.
- R8: Among pending, enabled lines the winner has the highest level, then the highest priority, then the highest number. The level is the top L control bits, where L is split byte bits 4:1. The priority is the next (implemented − L) bits. Both are padded below with ones.
- R9: The request is high only when the winner's level is strictly greater than the threshold byte.
- R10: With the request, the block outputs the winner's number, its padded level and its vectored flag (attribute bit 0). Outputs are registered, one cycle after the pending and configuration state.
- R11: Reserved bits of the split, pending, enable and attribute bytes read 0. Offsets that are not mapped, including groups past the last line, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational from bus_addr while bus_en and not bus_we |
| irq_in | input | NUM_IRQ | Asynchronous interrupt inputs |
| irq_ack | input | 1 | Core acknowledge strobe |
| ack_id | input | IDW | Line being acknowledged |
| req | output | 1 | Interrupt request to the core |
| req_id | output | IDW | Winning line number |
| req_level | output | 8 | Winning padded level |
| req_shv | output | 1 | Winning line's vectored flag |

## Verification
The assertions check on every cycle that any arbitration winner is both pending and enabled and that no winner appears without a candidate. They also check that a raised request carries a level above the threshold of the previous cycle, that level-triggered pending flags track the synchronized inputs, and that reads return ones in unimplemented control bits and zeros in reserved flag bits. The ordering rules can only be shown by the bench scenarios: how level, priority and line number rank candidates, how changing the split moves the winner's level, the strict threshold comparison at equality, edge latching that survives input release, and clearing by write or acknowledge.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

  localparam logic [1:0] TRIG_LEVEL = 2'd0;
  localparam logic [1:0] TRIG_RISE  = 2'd1;
  localparam logic [1:0] TRIG_FALL  = 2'd2;

  localparam logic [1:0] SEL_PEND = 2'd0;
  localparam logic [1:0] SEL_EN   = 2'd1;
  localparam logic [1:0] SEL_ATTR = 2'd2;
  localparam logic [1:0] SEL_CTL  = 2'd3;

  // Ones in the control bits that are not implemented.
  function automatic logic [7:0] low_ones(input int ctl_bits);
    return 8'hFF >> ctl_bits;
  endfunction

  function automatic int clamp_nl(input logic [3:0] nl);
    return (nl > 4'd8) ? 8 : int'(nl);
  endfunction

  // Level field: top nl bits kept, rest forced to one.
  function automatic logic [7:0] lvl_field(input logic [7:0] ctl, input logic [3:0] nl);
    logic [7:0] pad;
    pad = 8'hFF >> clamp_nl(nl);
    return ctl | pad;
  endfunction

  // Priority field: bits under the level, left-aligned, padded with ones.
  function automatic logic [7:0] prio_field(input logic [7:0] ctl, input logic [3:0] nl,
                                            input int ctl_bits);
    int n;
    int pb;
    logic [7:0] pad;
    logic [7:0] sh;
    n   = clamp_nl(nl);
    pb  = (ctl_bits > n) ? ctl_bits - n : 0;
    pad = 8'hFF >> pb;
    sh  = ctl << n;
    return (sh & ~pad) | pad;
  endfunction

endpackage

// File: rtl/lvl_intc_sync.sv
module lvl_intc_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= irq_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/lvl_intc_line.sv
module lvl_intc_line #(
  parameter int CTL_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] sel,
  input  logic [7:0] wdata,
  input  logic       lvl_in,
  input  logic       rise_in,
  input  logic       fall_in,
  input  logic       ack_hit,
  output logic       pend,
  output logic       en,
  output logic       shv,
  output logic [1:0] trig,
  output logic [7:0] ctl,
  output logic [7:0] rd_byte
);
  import lvl_intc_pkg::*;
  localparam logic [7:0] PAD = low_ones(CTL_BITS);

  logic wr_pend, edge_evt, is_edge;

  assign wr_pend  = wr_en && (sel == SEL_PEND);
  assign is_edge  = (trig == TRIG_RISE) || (trig == TRIG_FALL);
  assign edge_evt = (trig == TRIG_RISE) ? rise_in : fall_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (!is_edge) begin
      pend <= lvl_in;
    end else if (edge_evt) begin
      pend <= 1'b1;
    end else if (ack_hit) begin
      pend <= 1'b0;
    end else if (wr_pend) begin
      pend <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      shv  <= 1'b0;
      trig <= TRIG_LEVEL;
      ctl  <= PAD;
    end else if (wr_en) begin
      case (sel)
        SEL_EN:   en <= wdata[0];
        SEL_ATTR: begin
          shv  <= wdata[0];
          trig <= wdata[2:1];
        end
        SEL_CTL:  ctl <= wdata | PAD;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_PEND: rd_byte = {7'd0, pend};
      SEL_EN:   rd_byte = {7'd0, en};
      SEL_ATTR: rd_byte = {5'd0, trig, shv};
      default:  rd_byte = ctl;
    endcase
  end
endmodule

// File: rtl/lvl_intc_arb.sv
module lvl_intc_arb #(
  parameter int N        = 8,
  parameter int CTL_BITS = 4,
  parameter int IDW      = 3
) (
  input  logic [N-1:0]      cand,
  input  logic [N-1:0][7:0] ctl,
  input  logic [3:0]        nl,
  output logic              win_valid,
  output logic [IDW-1:0]    win_id,
  output logic [7:0]        win_lvl
);
  import lvl_intc_pkg::*;
  logic [15:0] best_key;
  logic [15:0] key;

  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    best_key  = '0;
    key       = '0;
    for (int i = 0; i < N; i++) begin
      key = {lvl_field(ctl[i], nl), prio_field(ctl[i], nl, CTL_BITS)};
      if (cand[i] && (!win_valid || key >= best_key)) begin
        win_valid = 1'b1;
        best_key  = key;
        win_id    = IDW'(i);
      end
    end
    win_lvl = best_key[15:8];
  end
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc #(
  parameter int          NUM_IRQ  = 8,
  parameter int          CTL_BITS = 4,
  parameter logic [7:0]  ARCH_VER = 8'h12,
  localparam int         IDW      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [12:0]        bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               irq_ack,
  input  logic [IDW-1:0]     ack_id,
  output logic               req,
  output logic [IDW-1:0]     req_id,
  output logic [7:0]         req_level,
  output logic               req_shv
);
  import lvl_intc_pkg::*;

  localparam logic [31:0] INFO = {7'd0, 4'(CTL_BITS), ARCH_VER, 13'(NUM_IRQ)};
  localparam logic [12:0] OFS_CFG = 13'h000;
  localparam logic [12:0] OFS_THR = 13'h00B;

  logic [3:0] nl_q;
  logic [7:0] thr_q;

  logic       wr_acc, rd_acc, arr_hit, line_ok;
  logic [9:0] line_idx;
  logic [1:0] byte_sel;

  logic [NUM_IRQ-1:0]      sync_lvl, sync_rise, sync_fall;
  logic [NUM_IRQ-1:0]      pend_vec, en_vec, shv_vec, lvl_trig_vec;
  logic [NUM_IRQ-1:0][7:0] ctl_vec, line_rd;
  logic                    win_valid;
  logic [IDW-1:0]          win_id;
  logic [7:0]              win_lvl;

  assign wr_acc   = bus_en && bus_we;
  assign rd_acc   = bus_en && !bus_we;
  assign arr_hit  = bus_addr[12];
  assign line_idx = bus_addr[11:2];
  assign byte_sel = bus_addr[1:0];
  assign line_ok  = arr_hit && (32'(line_idx) < 32'(NUM_IRQ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nl_q  <= '0;
      thr_q <= '0;
    end else if (wr_acc) begin
      if (bus_addr == OFS_CFG) nl_q  <= bus_wdata[4:1];
      if (bus_addr == OFS_THR) thr_q <= bus_wdata;
    end
  end

  lvl_intc_sync #(.N(NUM_IRQ)) sync_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .lvl(sync_lvl), .rise(sync_rise), .fall(sync_fall)
  );

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic [1:0] trig_w;
    logic       line_we;
    assign line_we = wr_acc && arr_hit && (line_idx == 10'(g));
    lvl_intc_line #(.CTL_BITS(CTL_BITS)) line_i (
      .clk(clk), .rst_n(rst_n), .wr_en(line_we), .sel(byte_sel), .wdata(bus_wdata),
      .lvl_in(sync_lvl[g]), .rise_in(sync_rise[g]), .fall_in(sync_fall[g]),
      .ack_hit(irq_ack && (ack_id == IDW'(g))),
      .pend(pend_vec[g]), .en(en_vec[g]), .shv(shv_vec[g]), .trig(trig_w),
      .ctl(ctl_vec[g]), .rd_byte(line_rd[g])
    );
    assign lvl_trig_vec[g] = (trig_w != TRIG_RISE) && (trig_w != TRIG_FALL);
  end

  lvl_intc_arb #(.N(NUM_IRQ), .CTL_BITS(CTL_BITS), .IDW(IDW)) arb_i (
    .cand(pend_vec & en_vec), .ctl(ctl_vec), .nl(nl_q),
    .win_valid(win_valid), .win_id(win_id), .win_lvl(win_lvl)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (rd_acc) begin
      if (line_ok) begin
        bus_rdata = line_rd[line_idx[IDW-1:0]];
      end else begin
        case (bus_addr)
          OFS_CFG:  bus_rdata = {3'd0, nl_q, 1'b0};
          13'h004:  bus_rdata = INFO[7:0];
          13'h005:  bus_rdata = INFO[15:8];
          13'h006:  bus_rdata = INFO[23:16];
          13'h007:  bus_rdata = INFO[31:24];
          OFS_THR:  bus_rdata = thr_q;
          default:  bus_rdata = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req       <= 1'b0;
      req_id    <= '0;
      req_level <= '0;
      req_shv   <= 1'b0;
    end else begin
      req       <= win_valid && (win_lvl > thr_q);
      req_id    <= win_id;
      req_level <= win_lvl;
      req_shv   <= shv_vec[win_id];
    end
  end
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
  parameter int N        = 8,
  parameter int CTL_BITS = 4,
  parameter int IDW      = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_en,
  input logic           bus_we,
  input logic [12:0]    bus_addr,
  input logic [7:0]     bus_rdata,
  input logic [N-1:0]   pend_vec,
  input logic [N-1:0]   en_vec,
  input logic [N-1:0]   lvl_trig_vec,
  input logic [N-1:0]   sync_lvl,
  input logic           win_valid,
  input logic [IDW-1:0] win_id,
  input logic [7:0]     thr_q,
  input logic           req,
  input logic [7:0]     req_level
);
  localparam logic [7:0] PAD = 8'hFF >> CTL_BITS;

  logic rd_ctl, rd_flag;
  assign rd_ctl  = bus_en && !bus_we && bus_addr[12] && (bus_addr[1:0] == 2'b11)
                   && (32'(bus_addr[11:2]) < 32'(N));
  assign rd_flag = bus_en && !bus_we && bus_addr[12] && !bus_addr[1];

  // R7
  win_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pend_vec[win_id] && en_vec[win_id]));

  // R7
  no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & en_vec) == '0) |-> !win_valid);

  // R9
  req_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (req_level > $past(thr_q)));

  // R9
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(win_valid) |-> !req);

  // R3
  ctl_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl |-> ((bus_rdata & PAD) == PAD));

  // R11
  flag_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flag |-> (bus_rdata[7:1] == 7'd0));

  for (genvar g = 0; g < N; g++) begin : g_lvl
    // R4
    lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lvl_trig_vec[g]) |-> (pend_vec[g] == $past(sync_lvl[g])));
  end
endmodule

bind lvl_intc lvl_intc_chk #(.N(NUM_IRQ), .CTL_BITS(CTL_BITS), .IDW(IDW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pend_vec(pend_vec), .en_vec(en_vec),
  .lvl_trig_vec(lvl_trig_vec), .sync_lvl(sync_lvl), .win_valid(win_valid),
  .win_id(win_id), .thr_q(thr_q), .req(req), .req_level(req_level)
);

// File: tb/lvl_intc_tb_top.sv
module lvl_intc_tb_top;
  localparam int NI = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [12:0]   bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NI-1:0] irq_in = '0;
  logic          irq_ack = 1'b0;
  logic [IW-1:0] ack_id = '0;
  logic          req;
  logic [IW-1:0] req_id;
  logic [7:0]    req_level;
  logic          req_shv;

  always #2.5 clk = ~clk;

  lvl_intc #(.NUM_IRQ(NI), .CTL_BITS(4), .ARCH_VER(8'h12)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_ack(irq_ack),
    .ack_id(ack_id), .req(req), .req_id(req_id), .req_level(req_level), .req_shv(req_shv)
  );

  typedef struct {
    bit         is_req;
    logic [7:0] exp;
    bit         exp_req;
    int         exp_id;
    logic [7:0] exp_lvl;
    bit         exp_shv;
    string      tag;
  } item_t;

  item_t sbq[$];
  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Level as the requirement states it: top L bits, ones below.
  function automatic logic [7:0] exp_level(input logic [7:0] ctl_rd, input int l);
    return ctl_rd | ((l >= 8) ? 8'h00 : (8'hFF >> l));
  endfunction

  // Monitor: compares queued expectations away from the active edge.
  always begin
    @(negedge clk);
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      tests++;
      if (!it.is_req) begin
        if (bus_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: rdata got %h exp %h", it.tag, bus_rdata, it.exp);
        end
      end else if (req !== it.exp_req ||
                   (it.exp_req && (int'(req_id) != it.exp_id || req_level !== it.exp_lvl
                                   || req_shv !== it.exp_shv))) begin
        fails++;
        $display("FAIL %s: req/id/lvl/shv got %b/%0d/%h/%b exp %b/%0d/%h/%b", it.tag,
                 req, req_id, req_level, req_shv, it.exp_req, it.exp_id, it.exp_lvl,
                 it.exp_shv);
      end
    end
  end

  task automatic rd_chk(input logic [12:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    it = '{is_req: 1'b0, exp: e, exp_req: 1'b0, exp_id: 0, exp_lvl: 8'h00,
           exp_shv: 1'b0, tag: tag};
    sbq.push_back(it);
    @(negedge clk);
    @(posedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic req_chk(input bit r, input int id, input logic [7:0] l, input bit s,
                         input string tag);
    item_t it;
    @(posedge clk); #1;
    it = '{is_req: 1'b1, exp: 8'h00, exp_req: r, exp_id: id, exp_lvl: l,
           exp_shv: s, tag: tag};
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
  endtask

  task automatic drive_irq(input int k, input logic v);
    @(posedge clk); #1;
    irq_in[k] = v;
    settle();
  endtask

  function automatic logic [12:0] grp(input int n, input int b);
    return 13'(32'h1000 + 4 * n + b);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();

    // R1 reset state
    rd_chk(13'h000, 8'h00, "R1 cfg");
    rd_chk(13'h00B, 8'h00, "R1 thr");
    rd_chk(grp(0, 0), 8'h00, "R1 pend");
    rd_chk(grp(3, 1), 8'h00, "R1 en");
    rd_chk(grp(7, 2), 8'h00, "R1 attr");
    rd_chk(grp(0, 3), 8'h0F, "R1 ctl");
    req_chk(1'b0, 0, 8'h00, 1'b0, "R1 req");

    // R2 info word 0x00824008
    rd_chk(13'h004, 8'h08, "R2 b0");
    rd_chk(13'h005, 8'h40, "R2 b1");
    rd_chk(13'h006, 8'h82, "R2 b2");
    wr(13'h007, 8'hFF);
    rd_chk(13'h007, 8'h00, "R2 b3");

    // R3 unimplemented control bits
    wr(grp(0, 3), 8'h00);
    rd_chk(grp(0, 3), 8'h0F, "R3 zero");
    wr(grp(0, 3), 8'hA5);
    rd_chk(grp(0, 3), 8'hAF, "R3 mix");

    // R11 reserved and unmapped
    wr(grp(0, 1), 8'hFF);
    rd_chk(grp(0, 1), 8'h01, "R11 en rsv");
    wr(grp(0, 1), 8'h00);
    wr(13'h002, 8'h55);
    rd_chk(13'h002, 8'h00, "R11 unmapped");
    wr(grp(NI, 3), 8'hF0);
    rd_chk(grp(NI, 3), 8'h00, "R11 past last");
    wr(13'h000, 8'hFF);
    rd_chk(13'h000, 8'h1E, "R11 cfg rsv");
    wr(13'h000, 8'h04);
    rd_chk(13'h000, 8'h04, "R11 cfg L=2");

    // R4 level trigger, line 1
    wr(grp(1, 3), 8'h40);
    wr(grp(1, 1), 8'h01);
    drive_irq(1, 1'b1);
    rd_chk(grp(1, 0), 8'h01, "R4 follow high");
    req_chk(1'b1, 1, exp_level(8'h4F, 2), 1'b0, "R4 req");
    wr(grp(1, 0), 8'h00);
    rd_chk(grp(1, 0), 8'h01, "R4 write ignored");
    drive_irq(1, 1'b0);
    rd_chk(grp(1, 0), 8'h00, "R4 follow low");
    req_chk(1'b0, 0, 8'h00, 1'b0, "R4 req drop");

    // R5 rising edge with vectored flag, line 2
    wr(grp(2, 2), 8'h03);
    rd_chk(grp(2, 2), 8'h03, "R5 attr");
    wr(grp(2, 3), 8'h80);
    wr(grp(2, 1), 8'h01);
    drive_irq(2, 1'b1);
    drive_irq(2, 1'b0);
    rd_chk(grp(2, 0), 8'h01, "R5 latched");
    req_chk(1'b1, 2, exp_level(8'h8F, 2), 1'b1, "R10 id/lvl/shv");
    wr(grp(2, 0), 8'h00);
    settle();
    rd_chk(grp(2, 0), 8'h00, "R5 sw clear");
    drive_irq(2, 1'b1);
    drive_irq(2, 1'b0);
    @(posedge clk); #1;
    irq_ack = 1'b1; ack_id = 3'd2;
    @(posedge clk); #1;
    irq_ack = 1'b0;
    settle();
    rd_chk(grp(2, 0), 8'h00, "R5 ack clear");
    req_chk(1'b0, 0, 8'h00, 1'b0, "R5 req gone");

    // R6 falling edge, line 3
    wr(grp(3, 2), 8'h04);
    wr(grp(3, 3), 8'h80);
    wr(grp(3, 1), 8'h01);
    drive_irq(3, 1'b1);
    rd_chk(grp(3, 0), 8'h00, "R6 rise no set");
    drive_irq(3, 1'b0);
    rd_chk(grp(3, 0), 8'h01, "R6 fall set");
    req_chk(1'b1, 3, 8'hBF, 1'b0, "R6 req");
    wr(grp(3, 0), 8'h00);
    settle();
    rd_chk(grp(3, 0), 8'h00, "R6 clear");

    // R7 pending but disabled, line 4
    wr(grp(4, 3), 8'hF0);
    drive_irq(4, 1'b1);
    rd_chk(grp(4, 0), 8'h01, "R7 pending");
    req_chk(1'b0, 0, 8'h00, 1'b0, "R7 masked");

    // R8 arbitration, lines 5 and 6 with L=2
    wr(grp(5, 3), 8'h40);
    wr(grp(6, 3), 8'h70);
    wr(grp(5, 1), 8'h01);
    wr(grp(6, 1), 8'h01);
    drive_irq(5, 1'b1);
    drive_irq(6, 1'b1);
    req_chk(1'b1, 6, 8'h7F, 1'b0, "R8 priority");
    wr(grp(5, 3), 8'h70);
    settle();
    req_chk(1'b1, 6, 8'h7F, 1'b0, "R8 id tie");
    wr(grp(5, 3), 8'h80);
    settle();
    req_chk(1'b1, 5, 8'hBF, 1'b0, "R8 level first");

    // R9 strict threshold
    wr(13'h00B, 8'hBE);
    settle();
    req_chk(1'b1, 5, 8'hBF, 1'b0, "R9 above");
    wr(13'h00B, 8'hBF);
    settle();
    req_chk(1'b0, 0, 8'h00, 1'b0, "R9 equal");
    wr(13'h00B, 8'hC0);
    settle();
    req_chk(1'b0, 0, 8'h00, 1'b0, "R9 below");
    wr(13'h00B, 8'h00);

    // R8 split changes the level field
    wr(13'h000, 8'h00);
    settle();
    req_chk(1'b1, 5, exp_level(8'h8F, 0), 1'b0, "R8 L=0");
    wr(13'h000, 8'h08);
    settle();
    req_chk(1'b1, 5, exp_level(8'h8F, 4), 1'b0, "R8 L=4");

    while (sbq.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule